// File: doc/BRIEF.md
# Multiphase Counter Time-to-Digital Converter

The converter measures the time between a start event and a stop event with sub-period resolution and no delay-line interpolator. A bank of binary counters runs from a multiphase clock. Each counter is clocked by one edge polarity of one phase. With 16 evenly spaced phases at 400 MHz, the 32 counters together sample the gate at 12.8 GHz. Adding their values gives the gated interval in units of 78.125 ps, in one interpolation stage with no coarse/fine split.

Software arms the converter, which clears every counter and raises busy. A start pulse opens the gate and the next stop pulse closes it. After a fixed settling wait, a sequential accumulator sums the counters into the result register and raises done. A sticky overflow flag reports a wrap of any counter. The counter width is a parameter, so the range can be extended beyond about 164 µs.

Top module: `mpc_tdc`

## Requirements
- R1: While reset is asserted and right after its release, busy_o, done_o and ovf_o are low and result_o is zero.
- R2: arm_i is accepted in every state and takes priority over start and stop. In the cycle after the arm edge, busy_o is 1, done_o is 0, ovf_o is 0 and result_o is 0, and all counters are cleared. A start sampled on either of the two edges that follow the arm edge is ignored.
- R3: A start sampled in the armed state opens the gate on that edge. The stop sampled k edges later closes it. The gate is therefore open for exactly k system cycles.
- R4: result_o is the sum of the 2*NPH counters. Counter 2i counts rising edges and counter 2i+1 counts falling edges of phase i while the gate is open. One LSB is the phase period divided by 2*NPH. With the defaults and a 100 MHz system clock, each counter gains 4 per gated cycle, so a k-cycle gate reads 128*k.
- R5: A stop with no accepted start before it is ignored and the converter stays armed. This includes a stop in the same cycle as the accepted start.
- R6: A start while the gate is open is ignored, and the measurement runs on until the stop.
- R7: After the closing stop edge Q, the block waits 4 settling cycles and then accumulates for 32 cycles. done_o rises and busy_o falls together after edge Q+36. busy_o and done_o are never high together.
- R8: If any counter passes 2^CNT_W-1 during a measurement, ovf_o rises together with done_o. The result then holds the sum of the wrapped counts, each taken modulo 2^CNT_W. The next arm clears ovf_o.
- R9: While done, result_o, ovf_o and done_o hold. Start and stop are ignored until the next arm.
- R10: CNT_W sets the range. With 16 bits, a gate of 16383 cycles (4*16383 = 65532 per counter) reads 2097024 without overflow, and 16384 cycles overflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ph_clk_i | input | NPH | Evenly spaced phase clocks |
| arm_i | input | 1 | Clear and arm pulse |
| start_i | input | 1 | Start event pulse |
| stop_i | input | 1 | Stop event pulse |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | Result valid |
| ovf_o | output | 1 | Sticky counter wrap flag |
| result_o | output | CNT_W+log2(2*NPH) | Interval in fine-resolution units |

## Verification
Several rules hold on every cycle and are checked there: the control sequence is legal, the gate follows accepted start and stop pulses, an orphan stop or a repeated start leaves the gate alone, arm clears the outputs, and done holds its result. Overflow may only appear as done rises. Only the bench scenarios can show the numeric value of the sum. That value depends on 32 counters in their own phase domains seeing the same gate window, on the exact 36-cycle completion latency, and on the wrap boundary at 2^16 counts per counter.

// File: rtl/mpc_tdc_pkg.sv
`timescale 1ps/1ps
package mpc_tdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_ARMED, ST_RUN, ST_SETTLE, ST_SUM, ST_DONE
  } tdc_state_e;
endpackage

// File: rtl/tdc_edge_cnt.sv
`timescale 1ps/1ps
module tdc_edge_cnt #(
  parameter int CNT_W = 16,
  parameter bit NEG   = 1'b0
) (
  input  logic             ph_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [1:0]       gate_sq, clr_sq;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = wrap_q;
    if (clr_sq[1]) begin
      cnt_d  = '0;
      wrap_d = 1'b0;
    end else if (gate_sq[1]) begin
      cnt_d  = cnt_q + 1'b1;
      wrap_d = wrap_q | (&cnt_q);
    end
  end

  // gate and clear resynchronised into this edge's own domain
  if (NEG) begin : g_neg
    always_ff @(negedge ph_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gate_sq <= '0;
        clr_sq  <= '0;
        cnt_q   <= '0;
        wrap_q  <= 1'b0;
      end else begin
        gate_sq <= {gate_sq[0], gate_i};
        clr_sq  <= {clr_sq[0], clr_i};
        cnt_q   <= cnt_d;
        wrap_q  <= wrap_d;
      end
    end
  end else begin : g_pos
    always_ff @(posedge ph_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gate_sq <= '0;
        clr_sq  <= '0;
        cnt_q   <= '0;
        wrap_q  <= 1'b0;
      end else begin
        gate_sq <= {gate_sq[0], gate_i};
        clr_sq  <= {clr_sq[0], clr_i};
        cnt_q   <= cnt_d;
        wrap_q  <= wrap_d;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/tdc_ctrl.sv
`timescale 1ps/1ps
module tdc_ctrl import mpc_tdc_pkg::*; #(
  parameter int  CLR_CYC    = 2,
  parameter int  SETTLE_CYC = 4,
  localparam int TMAX       = (CLR_CYC > SETTLE_CYC) ? CLR_CYC : SETTLE_CYC,
  localparam int TW         = $clog2(TMAX + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sum_fin_i,
  output logic       gate_o,
  output logic       clr_o,
  output logic       sum_run_o,
  output tdc_state_e st_o
);
  tdc_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          gate_q, gate_d;
  logic          clr_q;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q + 1'b1;
    gate_d = gate_q;
    if (arm_i) begin
      st_d   = ST_CLEAR;
      tmr_d  = '0;
      gate_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_CLEAR:  if (tmr_q == TW'(CLR_CYC - 1)) st_d = ST_ARMED;
        ST_ARMED:  if (start_i) begin
                     st_d   = ST_RUN;
                     gate_d = 1'b1;
                   end
        ST_RUN:    if (stop_i) begin
                     st_d   = ST_SETTLE;
                     tmr_d  = '0;
                     gate_d = 1'b0;
                   end
        ST_SETTLE: if (tmr_q == TW'(SETTLE_CYC - 1)) st_d = ST_SUM;
        ST_SUM:    if (sum_fin_i) st_d = ST_DONE;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      gate_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      gate_q <= gate_d;
      clr_q  <= (st_d == ST_CLEAR); // registered: crosses into phase domains
    end
  end

  assign gate_o    = gate_q;
  assign clr_o     = clr_q;
  assign sum_run_o = (st_q == ST_SUM);
  assign st_o      = st_q;
endmodule

// File: rtl/tdc_accum.sv
`timescale 1ps/1ps
module tdc_accum #(
  parameter int  NCNT  = 32,
  parameter int  CNT_W = 16,
  localparam int IW    = $clog2(NCNT),
  localparam int RES_W = CNT_W + IW
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       run_i,
  input  logic [NCNT-1:0][CNT_W-1:0] cnt_i,
  input  logic [NCNT-1:0]            wrap_i,
  output logic                       fin_o,
  output logic [RES_W-1:0]           result_o,
  output logic                       ovf_o
);
  logic [IW-1:0]    idx_q;
  logic [RES_W-1:0] acc_q, sum, res_q;
  logic             ovf_q, last;

  assign last  = (idx_q == IW'(NCNT - 1));
  assign sum   = acc_q + RES_W'(cnt_i[idx_q]);
  assign fin_o = run_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      acc_q <= '0;
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (run_i) begin
        idx_q <= idx_q + 1'b1;
        acc_q <= sum;
      end else begin
        idx_q <= '0;
        acc_q <= '0;
      end
      if (flush_i) begin
        res_q <= '0;
        ovf_q <= 1'b0;
      end else if (fin_o) begin
        res_q <= sum;
        ovf_q <= |wrap_i;
      end
    end
  end

  assign result_o = res_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/mpc_tdc.sv
`timescale 1ps/1ps
module mpc_tdc import mpc_tdc_pkg::*; #(
  parameter int  NPH        = 16,
  parameter int  CNT_W      = 16,
  parameter int  CLR_CYC    = 2,
  parameter int  SETTLE_CYC = 4,
  localparam int NCNT       = 2 * NPH,
  localparam int RES_W      = CNT_W + $clog2(NCNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPH-1:0]   ph_clk_i,
  input  logic             arm_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovf_o,
  output logic [RES_W-1:0] result_o
);
  logic                       gate, clr, sum_run, sum_fin;
  logic [NCNT-1:0][CNT_W-1:0] cnt;
  logic [NCNT-1:0]            wrap;
  tdc_state_e                 st;

  tdc_ctrl #(
    .CLR_CYC   (CLR_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .sum_fin_i(sum_fin),
    .gate_o   (gate),
    .clr_o    (clr),
    .sum_run_o(sum_run),
    .st_o     (st)
  );

  for (genvar gi = 0; gi < NPH; gi++) begin : g_ph
    tdc_edge_cnt #(.CNT_W(CNT_W), .NEG(1'b0)) u_rise (
      .ph_i  (ph_clk_i[gi]),
      .rst_ni(rst_ni),
      .gate_i(gate),
      .clr_i (clr),
      .cnt_o (cnt[2*gi]),
      .wrap_o(wrap[2*gi])
    );
    tdc_edge_cnt #(.CNT_W(CNT_W), .NEG(1'b1)) u_fall (
      .ph_i  (ph_clk_i[gi]),
      .rst_ni(rst_ni),
      .gate_i(gate),
      .clr_i (clr),
      .cnt_o (cnt[2*gi+1]),
      .wrap_o(wrap[2*gi+1])
    );
  end

  tdc_accum #(.NCNT(NCNT), .CNT_W(CNT_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (arm_i),
    .run_i   (sum_run),
    .cnt_i   (cnt),
    .wrap_i  (wrap),
    .fin_o   (sum_fin),
    .result_o(result_o),
    .ovf_o   (ovf_o)
  );

  assign busy_o = (st != ST_IDLE) && (st != ST_DONE);
  assign done_o = (st == ST_DONE);
endmodule

// File: rtl/mpc_tdc_chk.sv
`timescale 1ps/1ps
module mpc_tdc_chk import mpc_tdc_pkg::*; #(
  parameter int RES_W = 21
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic             start_i,
  input logic             stop_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             ovf_o,
  input logic [RES_W-1:0] result_o,
  input logic             gate_i,
  input tdc_state_e       st_i
);
  p_arm_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> busy_o && !done_o && !ovf_o && (result_o == '0));

  p_start_opens_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ARMED && start_i && !arm_i) |=> gate_i && st_i == ST_RUN);

  p_stop_closes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_RUN && stop_i && !arm_i) |=> !gate_i && st_i == ST_SETTLE);

  p_orphan_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ARMED && stop_i && !start_i && !arm_i) |=> !gate_i && st_i == ST_ARMED);

  p_restart_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_RUN && !stop_i && !arm_i) |=> gate_i);

  p_busy_done_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  p_ovf_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $rose(done_o));

  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> done_o && $stable(result_o) && $stable(ovf_o));
endmodule

bind mpc_tdc mpc_tdc_chk #(.RES_W(RES_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .arm_i   (arm_i),
  .start_i (start_i),
  .stop_i  (stop_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ovf_o   (ovf_o),
  .result_o(result_o),
  .gate_i  (gate),
  .st_i    (st)
);

// File: tb/mpc_tdc_test.sv
`timescale 1ps/1ps
module mpc_tdc_test;
  localparam int     NPH     = 16;
  localparam int     CNT_W   = 16;
  localparam int     RES_W   = CNT_W + 5;
  localparam longint PER_CYC = 4;  // phase periods per system cycle
  localparam longint WRAP    = longint'(1) << CNT_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 1'b0, start = 1'b0, stop = 1'b0;
  logic [NPH-1:0] ph;
  logic busy, done, ovf;
  logic [RES_W-1:0] result;
  int n_chk = 0, n_fail = 0;
  bit fin = 1'b0;

  always #5000 clk = ~clk;

  // phases spaced by 1/32 of 2.5 ns, offset so no edge meets a system edge
  for (genvar gi = 0; gi < NPH; gi++) begin : g_clk
    localparam int OFF = 20 + (gi * 625) / 8;
    logic pc = 1'b0;
    initial begin
      #(OFF);
      forever #1250 pc = ~pc;
    end
    assign ph[gi] = pc;
  end

  mpc_tdc uut (
    .clk_i(clk), .rst_ni(rst_n), .ph_clk_i(ph),
    .arm_i(arm), .start_i(start), .stop_i(stop),
    .busy_o(busy), .done_o(done), .ovf_o(ovf), .result_o(result)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: 0 idle 1 clear 2 armed 3 run 4 settle 5 sum 6 done
  int m_st, m_t;
  longint m_open, m_res;
  bit m_ovf;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_open = 0; m_res = 0; m_ovf = 1'b0;
    end else if (arm) begin
      m_st = 1; m_t = 0; m_res = 0; m_ovf = 1'b0;
    end else begin
      case (m_st)
        1: begin m_t++; if (m_t == 2) m_st = 2; end
        2: if (start) begin m_st = 3; m_open = 0; end
        3: begin m_open++; if (stop) begin m_st = 4; m_t = 0; end end
        4: begin m_t++; if (m_t == 4) begin m_st = 5; m_t = 0; end end
        5: begin
          m_t++;
          if (m_t == 32) begin
            m_st  = 6;
            m_res = 2 * NPH * ((PER_CYC * m_open) % WRAP);
            m_ovf = (PER_CYC * m_open) >= WRAP;
          end
        end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk("R7 busy per cycle", longint'(busy), longint'(m_st >= 1 && m_st <= 5));
      chk("R7 done per cycle", longint'(done), longint'(m_st == 6));
      chk("R8 ovf per cycle", longint'(ovf), longint'(m_ovf));
      chk("R4 result per cycle", longint'(result), m_res);
    end
  end

  task automatic arm_p();
    arm = 1'b1; @(negedge clk); arm = 1'b0;
  endtask
  task automatic start_p();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask
  task automatic stop_p();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask
  task automatic wait_done();
    for (int i = 0; i < 100; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int k, input string tag);
    longint per;
    arm_p();
    repeat (2) @(negedge clk);
    start_p();
    repeat (k - 1) @(negedge clk);
    stop_p();
    wait_done();
    per = PER_CYC * k;
    chk($sformatf("%s done k=%0d", tag, k), longint'(done), 1);
    chk($sformatf("%s result k=%0d", tag, k), longint'(result), 2 * NPH * (per % WRAP));
    chk($sformatf("R8 ovf k=%0d", k), longint'(ovf), longint'(per >= WRAP));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", longint'(busy), 0);
    chk("R1 result in reset", longint'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", longint'(busy), 0);
    chk("R1 done", longint'(done), 0);
    chk("R1 ovf", longint'(ovf), 0);
    chk("R1 result", longint'(result), 0);

    measure(1, "R4");
    measure(5, "R3");
    measure(37, "R4");
    measure(100, "R4");

    // orphan stop in armed state
    arm_p();
    repeat (2) @(negedge clk);
    stop_p();
    repeat (10) @(negedge clk);
    chk("R5 still busy after orphan stop", longint'(busy), 1);
    chk("R5 no done after orphan stop", longint'(done), 0);
    start_p();
    repeat (9) @(negedge clk);
    stop_p();
    wait_done();
    chk("R5 result after orphan stop", longint'(result), 1280);

    // stop together with the accepted start
    arm_p();
    repeat (2) @(negedge clk);
    start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    repeat (6) @(negedge clk);
    stop_p();
    wait_done();
    chk("R5 same-cycle stop ignored", longint'(result), 896);

    // second start while gate is open
    arm_p();
    repeat (2) @(negedge clk);
    start_p();
    repeat (2) @(negedge clk);
    start_p();
    repeat (13) @(negedge clk);
    stop_p();
    wait_done();
    chk("R6 second start ignored", longint'(result), 2176);

    // start during clear window
    arm_p();
    start_p();
    repeat (9) @(negedge clk);
    stop_p();
    repeat (40) @(negedge clk);
    chk("R2 start in clear ignored busy", longint'(busy), 1);
    chk("R2 start in clear ignored done", longint'(done), 0);
    start_p();
    repeat (2) @(negedge clk);
    stop_p();
    wait_done();
    chk("R2 result after clear window", longint'(result), 384);

    // re-arm in the middle of a run
    arm_p();
    repeat (2) @(negedge clk);
    start_p();
    repeat (20) @(negedge clk);
    arm_p();
    chk("R2 rearm result cleared", longint'(result), 0);
    chk("R2 rearm busy", longint'(busy), 1);
    repeat (2) @(negedge clk);
    start_p();
    repeat (8) @(negedge clk);
    stop_p();
    wait_done();
    chk("R2 result after rearm", longint'(result), 1152);

    // start/stop while done
    start_p();
    repeat (5) @(negedge clk);
    stop_p();
    repeat (50) @(negedge clk);
    chk("R9 done held", longint'(done), 1);
    chk("R9 result held", longint'(result), 1152);

    // range boundary
    measure(16383, "R10");
    measure(16384, "R8");
    arm_p();
    chk("R8 ovf cleared by arm", longint'(ovf), 0);
    repeat (3) @(negedge clk);

    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule